// File: doc/BRIEF.md
# Cross-Domain Latched Free-Running Counter

This block keeps a free-running counter on a reference clock. The counter is twice the bus data width: 64 bits with the default 32-bit data path. Software on an unrelated bus clock reads it through a small register port. Software cannot read the live counter directly. It writes a command bit into the control word, and the block then captures a coherent copy of the counter into a low word and a high word on the bus side. The command bit reads back as 1 while the capture is under way. It drops to 0 by itself once both words hold the same snapshot.

A toggle handshake carries the request into the reference domain through a two-flop synchronizer. A second toggle carries the completion back the same way. When the request arrives, the reference side copies the counter into a holding register. That register then stays unchanged until the next request. The bus side loads its words from the holding register only after it has seen the synchronized completion. No multi-bit value is ever sampled while it is changing. A second command bit uses the same handshake to zero the counter.

The register port has no back-pressure. A write takes effect on the bus clock edge where `bus_wr_en` is high. A read is combinational from `bus_addr`. Register offsets are byte offsets and only address bits [3:2] select the word: 0x0 is control, 0x4 is the low word, 0x8 is the high word, and 0xC is unmapped.

Top module: `ctr_snapshot_top`

## Requirements
- R1: After both resets, the control, low, high and unmapped offsets all read 0.
- R2: The counter advances by one on every reference clock edge, and it wraps from all-ones to zero across the full 2*DATA_W bits.
- R3: With no capture pending, writing control (0x0) with bit 0 set makes control bit 0 read 1 from the next bus cycle.
- R4: A pending command bit returns to 0 within 20 bus cycles when the reference clock is at least half the bus clock rate.
- R5: Once control bit 0 has dropped, the value {high word at 0x8, low word at 0x4} is a single counter value. It is no older than the value at the time of the write and no newer than the value when the bit was seen low.
- R6: The low and high words change only when a capture started with bit 0 completes. A clear-only command leaves them as they were.
- R7: A control write while any command is pending is ignored. The control readback is unchanged and the new bits take no effect.
- R8: Writing control with neither bit 0 nor bit 1 set has no effect: nothing becomes pending and the words are unchanged.
- R9: Writing control with bit 1 set zeroes the counter through the handshake. Control bit 1 reads 1 until that is done, and it then self-clears.
- R10: Setting bits 0 and 1 together captures the counter value from just before the zeroing, then restarts the count from zero.
- R11: Control bits above bit 1 and the unmapped offset read 0. Writes to 0x4, 0x8 and 0xC change nothing.
- R12: The reference side answers each request exactly once. Its completion toggle changes only in the cycle after it detects a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register port clock |
| bus_rst_n | input | 1 | Active-low asynchronous reset, bus domain |
| ref_clk | input | 1 | Reference clock that drives the counter |
| ref_rst_n | input | 1 | Active-low asynchronous reset, reference domain |
| bus_wr_en | input | 1 | Write strobe, taken on the bus clock edge |
| bus_addr | input | ADDR_W (4) | Byte offset; bits [3:2] select the word |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for `bus_addr` |

## Verification
The bench builds the block with DATA_W = 8, so the counter is 16 bits wide. This makes a carry from the low word into the high word occur every 256 reference cycles. It also makes the full wrap at 65536 reference cycles reachable in one run. A sweep of about three hundred captures at staggered spacings crosses that wrap and many word carries. Each capture is checked against a window the bench computes by counting reference edges itself. The clear and combined commands are checked against windows measured from the moment of the clear.

// File: rtl/ctr_snap_pkg.sv
package ctr_snap_pkg;

  // bit positions inside the control word
  localparam int CTRL_SNAP_BIT = 0;
  localparam int CTRL_ZERO_BIT = 1;

  // word select taken from address bits [3:2]
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_LOW  = 2'd1,
    SEL_HIGH = 2'd2,
    SEL_NONE = 2'd3
  } word_sel_e;

  // command held stable on the bus side while a handshake is open
  typedef struct packed {
    logic zero;
    logic snap;
  } snap_cmd_t;

endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cs_ref_side.sv
module cs_ref_side
  import ctr_snap_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int STAGES = 2
) (
  input  logic             ref_clk,
  input  logic             ref_rst_n,
  input  logic             req_tgl_async,
  input  snap_cmd_t        cmd_async,
  output logic             ack_tgl,
  output logic             cap_pulse,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] hold
);
  logic req_s, req_d;

  cs_sync #(.STAGES(STAGES)) u_req_sync (
    .clk   (ref_clk),
    .rst_n (ref_rst_n),
    .d     (req_tgl_async),
    .q     (req_s)
  );

  // a new request shows up as a change of the synchronized toggle;
  // the command word has been stable since before the toggle flipped
  assign cap_pulse = req_s ^ req_d;

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      req_d   <= 1'b0;
      ack_tgl <= 1'b0;
      count   <= '0;
      hold    <= '0;
    end else begin
      req_d <= req_s;
      if (cap_pulse && cmd_async.zero) count <= '0;
      else                             count <= count + 1'b1;
      if (cap_pulse && cmd_async.snap) hold <= count;
      if (cap_pulse)                   ack_tgl <= req_s;
    end
  end
endmodule

// File: rtl/cs_bus_regs.sv
module cs_bus_regs
  import ctr_snap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int STAGES = 2,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ack_tgl_async,
  input  logic [CNT_W-1:0]  hold_async,
  output logic              req_tgl,
  output snap_cmd_t         cmd,
  output logic              pending,
  output logic [DATA_W-1:0] snap_lo,
  output logic [DATA_W-1:0] snap_hi
);
  logic      ack_s;
  logic      ctrl_wr;
  logic      start;
  logic      done;
  word_sel_e wsel;

  cs_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk   (bus_clk),
    .rst_n (bus_rst_n),
    .d     (ack_tgl_async),
    .q     (ack_s)
  );

  always_comb begin
    if (addr[ADDR_W-1:2] > (ADDR_W-2)'(3)) wsel = SEL_NONE;
    else                                   wsel = word_sel_e'(addr[3:2]);
  end

  assign pending = cmd.snap | cmd.zero;
  assign ctrl_wr = wr_en && (wsel == SEL_CTRL);
  assign start   = ctrl_wr && !pending &&
                   (wdata[CTRL_SNAP_BIT] || wdata[CTRL_ZERO_BIT]);
  // the answer toggle has caught up with the request toggle
  assign done    = pending && (ack_s == req_tgl);

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      req_tgl <= 1'b0;
      cmd     <= '0;
      snap_lo <= '0;
      snap_hi <= '0;
    end else if (start) begin
      req_tgl  <= ~req_tgl;
      cmd.snap <= wdata[CTRL_SNAP_BIT];
      cmd.zero <= wdata[CTRL_ZERO_BIT];
    end else if (done) begin
      cmd <= '0;
      if (cmd.snap) begin
        snap_lo <= hold_async[DATA_W-1:0];
        snap_hi <= hold_async[CNT_W-1:DATA_W];
      end
    end
  end
endmodule

// File: rtl/ctr_snapshot_top.sv
module ctr_snapshot_top
  import ctr_snap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int STAGES = 2
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              ref_clk,
  input  logic              ref_rst_n,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int CNT_W = 2 * DATA_W;

  logic             req_tgl, ack_tgl, cap_pulse, pending;
  snap_cmd_t        cmd;
  logic [CNT_W-1:0] count, hold;
  logic [DATA_W-1:0] snap_lo, snap_hi;

  cs_ref_side #(.CNT_W(CNT_W), .STAGES(STAGES)) u_ref (
    .ref_clk       (ref_clk),
    .ref_rst_n     (ref_rst_n),
    .req_tgl_async (req_tgl),
    .cmd_async     (cmd),
    .ack_tgl       (ack_tgl),
    .cap_pulse     (cap_pulse),
    .count         (count),
    .hold          (hold)
  );

  cs_bus_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAGES(STAGES)) u_bus (
    .bus_clk       (bus_clk),
    .bus_rst_n     (bus_rst_n),
    .wr_en         (bus_wr_en),
    .addr          (bus_addr),
    .wdata         (bus_wdata),
    .ack_tgl_async (ack_tgl),
    .hold_async    (hold),
    .req_tgl       (req_tgl),
    .cmd           (cmd),
    .pending       (pending),
    .snap_lo       (snap_lo),
    .snap_hi       (snap_hi)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[ADDR_W-1:2] <= (ADDR_W-2)'(3)) begin
      case (word_sel_e'(bus_addr[3:2]))
        SEL_CTRL: begin
          bus_rdata[CTRL_SNAP_BIT] = cmd.snap;
          bus_rdata[CTRL_ZERO_BIT] = cmd.zero;
        end
        SEL_LOW:  bus_rdata = snap_lo;
        SEL_HIGH: bus_rdata = snap_hi;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ctr_snapshot_chk.sv
module ctr_snapshot_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  localparam int CNT_W = 2 * DATA_W
) (
  input logic              bus_clk,
  input logic              bus_rst_n,
  input logic              ref_clk,
  input logic              ref_rst_n,
  input logic              bus_wr_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              pending,
  input logic              cmd_snap,
  input logic              cmd_zero,
  input logic              req_tgl,
  input logic              ack_tgl,
  input logic              cap_pulse,
  input logic [CNT_W-1:0]  count,
  input logic [DATA_W-1:0] snap_lo,
  input logic [DATA_W-1:0] snap_hi
);
  logic ctrl_wr;
  assign ctrl_wr = bus_wr_en && (bus_addr == '0);

  // R3
  snap_start_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (!pending && ctrl_wr && bus_wdata[0]) |=> (pending && cmd_snap));

  // R7
  busy_write_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (pending && ctrl_wr) |=> ($stable(req_tgl) && $stable(cmd_snap) && $stable(cmd_zero)));

  // R6
  snap_hold_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (!pending || !cmd_snap) |=> ($stable(snap_lo) && $stable(snap_hi)));

  // R11
  unmapped_read_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (bus_addr == ADDR_W'(12)) |-> (bus_rdata == '0));

  // R2
  count_step_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !(cap_pulse && cmd_zero) |=> (count == CNT_W'($past(count) + 1'b1)));

  // R9
  zero_count_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (cap_pulse && cmd_zero) |=> (count == '0));

  // R12
  ack_once_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !cap_pulse |=> $stable(ack_tgl));
endmodule

bind ctr_snapshot_top ctr_snapshot_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .bus_clk   (bus_clk),
  .bus_rst_n (bus_rst_n),
  .ref_clk   (ref_clk),
  .ref_rst_n (ref_rst_n),
  .bus_wr_en (bus_wr_en),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pending   (pending),
  .cmd_snap  (cmd.snap),
  .cmd_zero  (cmd.zero),
  .req_tgl   (req_tgl),
  .ack_tgl   (ack_tgl),
  .cap_pulse (cap_pulse),
  .count     (count),
  .snap_lo   (snap_lo),
  .snap_hi   (snap_hi)
);

// File: tb/ctr_snapshot_top_test.sv
module ctr_snapshot_top_test;
  localparam int  DATA_W     = 8;
  localparam int  ADDR_W     = 4;
  localparam int  STAGES     = 2;
  localparam int  CNT_W      = 2 * DATA_W;
  localparam time CLK_PERIOD = 10;
  localparam time REF_PERIOD = 14;

  logic              bus_clk = 1'b0, ref_clk = 1'b0;
  logic              bus_rst_n = 1'b0, ref_rst_n = 1'b0;
  logic              bus_wr_en = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;

  int vectors = 0;
  int misses  = 0;
  logic [31:0] ref_edges;

  ctr_snapshot_top #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAGES(STAGES)) uut (
    .bus_clk   (bus_clk),
    .bus_rst_n (bus_rst_n),
    .ref_clk   (ref_clk),
    .ref_rst_n (ref_rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  initial forever #(CLK_PERIOD/2) bus_clk = ~bus_clk;
  initial forever #(REF_PERIOD/2) ref_clk = ~ref_clk;

  // independent count of reference edges since reset release
  always @(posedge ref_clk or negedge ref_rst_n)
    if (!ref_rst_n) ref_edges <= '0;
    else            ref_edges <= ref_edges + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge bus_clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge bus_clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle(output int cycles);
    logic [DATA_W-1:0] c;
    cycles = 0;
    rd(0, c);
    while (c != 0 && cycles < 1000) begin
      @(negedge bus_clk);
      cycles++;
      rd(0, c);
    end
  endtask

  task automatic read_snap(output logic [CNT_W-1:0] v);
    logic [DATA_W-1:0] lo, hi;
    rd(4, lo);
    rd(8, hi);
    v = {hi, lo};
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    vectors++; misses++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [DATA_W-1:0] r;
    logic [CNT_W-1:0]  v, v_prev, lo_b, hi_b;
    int cyc;
    int wraps;
    longint cw, cd, w3, d3, lw, ld;

    repeat (3) @(negedge bus_clk);
    bus_rst_n = 1'b1; ref_rst_n = 1'b1;
    repeat (2) @(negedge bus_clk);

    // R1 reset state
    rd(0, r);  check(r == 0, "R1 ctrl", r, 0);
    rd(4, r);  check(r == 0, "R1 low", r, 0);
    rd(8, r);  check(r == 0, "R1 high", r, 0);
    rd(12, r); check(r == 0, "R1 unmapped", r, 0);

    // R2/R3/R4/R5 sweep of captures across word carries and the full wrap
    wraps = 0;
    v_prev = '0;
    for (int i = 0; i < 300; i++) begin
      repeat (240 + (i * 7) % 29) @(negedge ref_clk);
      @(negedge bus_clk);
      lo_b = ref_edges[CNT_W-1:0];
      wr(0, 8'h01);
      rd(0, r);
      check(r == 8'h01, "R3 snap bit set", r, 1);
      wait_idle(cyc);
      check(cyc <= 20, "R4 self-clear time", cyc, 20);
      hi_b = ref_edges[CNT_W-1:0];
      read_snap(v);
      check(CNT_W'(v - lo_b) <= CNT_W'(hi_b - lo_b), "R5 coherent window", v, lo_b);
      if (v < v_prev) wraps++;
      v_prev = v;
    end
    // R2 the 16-bit count wrapped to zero during the sweep
    check(wraps == ref_edges / 65536, "R2 wrap count", wraps, ref_edges / 65536);

    // R7 write while pending is ignored
    lo_b = ref_edges[CNT_W-1:0];
    wr(0, 8'h01);
    wr(0, 8'h03);
    rd(0, r);
    check(r == 8'h01, "R7 busy write ignored", r, 1);
    wait_idle(cyc);
    hi_b = ref_edges[CNT_W-1:0];
    read_snap(v);
    check(CNT_W'(v - lo_b) <= CNT_W'(hi_b - lo_b), "R7 no zeroing from ignored write", v, lo_b);
    repeat (10) @(negedge bus_clk);
    rd(0, r);
    check(r == 0, "R7 no second capture", r, 0);

    // R8 writing zero does nothing
    wr(0, 8'h00);
    rd(0, r);
    check(r == 0, "R8 ctrl stays idle", r, 0);
    read_snap(v_prev);
    check(v_prev == v, "R8 words unchanged", v_prev, v);

    // R11 unmapped bits and offsets
    wr(0, 8'h04);
    rd(0, r);
    check(r == 0, "R11 upper ctrl bit", r, 0);
    wr(4, 8'hFF); wr(8, 8'hFF); wr(12, 8'hFF);
    repeat (10) @(negedge bus_clk);
    read_snap(v_prev);
    check(v_prev == v, "R11 data words not writable", v_prev, v);
    rd(12, r);
    check(r == 0, "R11 unmapped reads zero", r, 0);

    // R9 clear-only command
    cw = ref_edges;
    wr(0, 8'h02);
    rd(0, r);
    check(r == 8'h02, "R9 zero bit pending", r, 2);
    wait_idle(cyc);
    cd = ref_edges;
    check(cyc <= 20, "R9 zero bit self-clears", cyc, 20);
    read_snap(v_prev);
    check(v_prev == v, "R6 words kept on clear-only", v_prev, v);
    repeat (50) @(negedge ref_clk);
    @(negedge bus_clk);
    lw = ref_edges;
    wr(0, 8'h01);
    wait_idle(cyc);
    ld = ref_edges;
    read_snap(v);
    check(v >= lw - cd && v <= ld - cw, "R9 count restarted from zero", v, lw - cd);

    // R10 capture and zero together
    repeat (100) @(negedge ref_clk);
    @(negedge bus_clk);
    w3 = ref_edges;
    wr(0, 8'h03);
    rd(0, r);
    check(r == 8'h03, "R10 both bits pending", r, 3);
    wait_idle(cyc);
    d3 = ref_edges;
    read_snap(v);
    check(v >= w3 - cd && v <= d3 - cw, "R10 pre-zero value captured", v, w3 - cd);
    repeat (30) @(negedge ref_clk);
    @(negedge bus_clk);
    lw = ref_edges;
    wr(0, 8'h01);
    wait_idle(cyc);
    ld = ref_edges;
    read_snap(v);
    check(v >= lw - d3 && v <= ld - w3, "R10 count restarted after capture", v, lw - d3);

    finish_run();
  end
endmodule